// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of interrupt vectors and a processor core. Each of ten vectors carries a request line and a two-bit level setting. Every clock the block picks the most urgent request that may preempt the handler now running. It registers a request to the core together with the entry address of the chosen vector.

When the core acknowledges, the running level rises to the level of the granted vector. The level that was running before is saved on a small internal stack. A return strobe restores the saved level, so handlers can nest up to three deep: low, then high, then top. A request is admitted only when its level is strictly above the running level. Among admitted requests the highest level wins, and within one level the lowest entry address wins. Mapping several sources onto one vector, per-source enables and the core itself are handled elsewhere.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, irq_o is 0, vec_addr_o is 0 and run_lvl_o is 0 (none); run_lvl_o encodes 0 none, 1 low, 2 high, 3 top.
- R2: The entry address of vector index n (0..9) is 3 + 8·n, driven on vec_addr_o whenever irq_o is 1.
- R3: The setting of vector n is lvl_cfg_i[2n+1:2n]. Code 3 means top only for n = 0 or 1. Code 2 means high only for n = 2..9. Every other code, including top requested for n ≥ 2 and high requested for n ≤ 1, means low.
- R4: A request whose level is equal to or below run_lvl_o is never presented.
- R5: Among admitted requests, the one with the highest level is presented.
- R6: Among admitted requests of the same highest level, the lowest vector index is presented.
- R7: irq_o and vec_addr_o are registered: they reflect req_i, lvl_cfg_i and the running level sampled at the previous clock edge; vec_addr_o is 0 whenever irq_o is 0.
- R8: ack_i while irq_o is 1 sets run_lvl_o, at the next edge, to the presented vector's level, saves the prior level, and forces irq_o to 0 for one cycle.
- R9: reti_i restores the most recently saved level, so nesting none→low→high→top unwinds in reverse order.
- R10: reti_i with nothing saved, ack_i while irq_o is 0, and reti_i in the same cycle as an accepted ack_i are all ignored; run_lvl_o otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Request line per vector, bit n for vector n |
| lvl_cfg_i | input | 20 | Two-bit level setting per vector |
| ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Core leaves the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 8 | Entry address of the presented vector |
| run_lvl_o | output | 2 | Level of the handler now running |

## Verification
A wrong saved-level entry stays hidden until the matching return. It then appears as a wrong run_lvl_o on the cycle after the return strobe, and as requests admitted or blocked wrongly from the following cycle. A wrong level mapping or tie-break shows within one cycle as a wrong vec_addr_o, or as irq_o high when it should be low. Sweeping every request pattern at every running level exposes each of these within a single sweep.

// File: rtl/nic_pkg.sv
package nic_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  // Effective level of vector idx given its raw two-bit setting.
  function automatic logic [1:0] map_level(input int unsigned idx,
                                           input int unsigned top_cnt,
                                           input logic [1:0] code);
    if (code == 2'd3 && idx < top_cnt)  return LVL_TOP;
    if (code == 2'd2 && idx >= top_cnt) return LVL_HIGH;
    return LVL_LOW;
  endfunction

  // Entry address of vector idx.
  function automatic int unsigned entry_addr(input int unsigned idx,
                                             input int unsigned base,
                                             input int unsigned stride);
    return base + stride * idx;
  endfunction

endpackage

// File: rtl/nic_level_map.sv
module nic_level_map #(
  parameter int NUM_VEC = 10,
  parameter int TOP_CNT = 2
) (
  input  logic [2*NUM_VEC-1:0]       cfg_i,
  output logic [NUM_VEC-1:0][1:0]    lvl_o
);
  import nic_pkg::*;

  for (genvar n = 0; n < NUM_VEC; n++) begin : g_map
    assign lvl_o[n] = map_level(n, TOP_CNT, cfg_i[2*n +: 2]);
  end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_VEC = 10,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]         req_i,
  input  logic [NUM_VEC-1:0][1:0]    lvl_i,
  input  logic [1:0]                 run_i,
  output logic                       found_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [1:0]                 lvl_o
);

  // Scan from the highest index down; ">=" lets a lower index of equal
  // level replace an earlier pick, so the lowest index wins ties.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = 2'd0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req_i[i] && (lvl_i[i] > run_i) && (lvl_i[i] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end

endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
  parameter int DEPTH  = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic [1:0]  push_val_i,
  output logic [1:0]  top_o,
  output logic        empty_o
);

  logic [DEPTH-1:0][1:0] mem_q;
  logic [PTR_W-1:0]      sp_q;
  logic                  full;

  assign empty_o = (sp_q == '0);
  assign full    = (sp_q == PTR_W'(DEPTH));
  assign top_o   = empty_o ? 2'd0 : mem_q[sp_q - PTR_W'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      sp_q  <= '0;
    end else if (push_i && !full) begin
      mem_q[sp_q] <= push_val_i;
      sp_q        <= sp_q + PTR_W'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - PTR_W'(1);
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_VEC    = 10,
  parameter int TOP_CNT    = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 8,
  parameter int STK_DEPTH  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VEC-1:0]    req_i,
  input  logic [2*NUM_VEC-1:0]  lvl_cfg_i,
  input  logic                  ack_i,
  input  logic                  reti_i,
  output logic                  irq_o,
  output logic [ADDR_W-1:0]     vec_addr_o,
  output logic [1:0]            run_lvl_o
);
  import nic_pkg::*;

  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0][1:0] eff_lvl;
  logic                    win_found;
  logic [IDX_W-1:0]        win_idx;
  logic [1:0]              win_lvl;
  logic [ADDR_W-1:0]       win_addr;

  logic                    irq_q;
  logic [ADDR_W-1:0]       vec_q;
  logic [1:0]              grant_lvl_q;
  logic [1:0]              run_q;

  // Named internal events, also observed by the checker.
  logic                    accept_ack;
  logic                    accept_ret;
  logic [1:0]              stk_top;
  logic                    stk_empty;

  nic_level_map #(.NUM_VEC(NUM_VEC), .TOP_CNT(TOP_CNT)) u_map (
    .cfg_i (lvl_cfg_i),
    .lvl_o (eff_lvl)
  );

  nic_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .req_i   (req_i),
    .lvl_i   (eff_lvl),
    .run_i   (run_q),
    .found_o (win_found),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  nic_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept_ack),
    .pop_i      (accept_ret),
    .push_val_i (run_q),
    .top_o      (stk_top),
    .empty_o    (stk_empty)
  );

  assign win_addr   = ADDR_W'(entry_addr(int'(win_idx), VEC_BASE, VEC_STRIDE));
  assign accept_ack = ack_i & irq_q;
  assign accept_ret = reti_i & ~accept_ack & ~stk_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= 1'b0;
      vec_q       <= '0;
      grant_lvl_q <= LVL_NONE;
    end else if (accept_ack) begin
      irq_q       <= 1'b0;
      vec_q       <= '0;
      grant_lvl_q <= LVL_NONE;
    end else begin
      irq_q       <= win_found;
      vec_q       <= win_found ? win_addr : '0;
      grant_lvl_q <= win_found ? win_lvl : LVL_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= LVL_NONE;
    else if (accept_ack) run_q <= grant_lvl_q;
    else if (accept_ret) run_q <= stk_top;
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = vec_q;
  assign run_lvl_o  = run_q;

endmodule

// File: rtl/nic_sva.sv
module nic_sva #(
  parameter int NUM_VEC    = 10,
  parameter int TOP_CNT    = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [1:0]        run_lvl_o,
  input logic [1:0]        grant_lvl,
  input logic              accept_ack,
  input logic              accept_ret,
  input logic              stk_empty
);

  localparam int ADDR_END = VEC_BASE + VEC_STRIDE * NUM_VEC;
  localparam int TOP_END  = VEC_BASE + VEC_STRIDE * TOP_CNT;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && run_lvl_o == 2'd0 && vec_addr_o == '0));

  assert_addr_on_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((int'(vec_addr_o) - VEC_BASE) % VEC_STRIDE == 0 &&
               int'(vec_addr_o) >= VEC_BASE && int'(vec_addr_o) < ADDR_END));

  assert_top_only_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && grant_lvl == 2'd3) |-> int'(vec_addr_o) < TOP_END);

  assert_above_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> grant_lvl > run_lvl_o);

  assert_idle_addr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> vec_addr_o == '0);

  assert_ack_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ack |=> !irq_o);

  assert_ack_raises_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ack |=> run_lvl_o > $past(run_lvl_o));

  assert_ret_lowers_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ret |=> run_lvl_o < $past(run_lvl_o));

  assert_level_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_ack && !accept_ret) |=> $stable(run_lvl_o));

  assert_empty_means_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> run_lvl_o == 2'd0);

endmodule

bind nest_irq_ctrl nic_sva #(
  .NUM_VEC(NUM_VEC), .TOP_CNT(TOP_CNT), .VEC_BASE(VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE), .ADDR_W(ADDR_W)
) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .vec_addr_o (vec_addr_o),
  .run_lvl_o  (run_lvl_o),
  .grant_lvl  (grant_lvl_q),
  .accept_ack (accept_ack),
  .accept_ret (accept_ret),
  .stk_empty  (stk_empty)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req = '0;
  logic [19:0] cfg = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq;
  logic [7:0]  vaddr;
  logic [1:0]  run;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  int m_run = 0;
  int m_stk[3];
  int m_sp = 0;
  bit m_irq = 1'b0;
  int m_vec = 0;
  int m_glvl = 0;

  always #4 clk = ~clk;  // 125 MHz

  nest_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_cfg_i(cfg),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_addr_o(vaddr), .run_lvl_o(run)
  );

  // R3 restated: top only on the first two vectors, high only on the rest.
  function automatic int ref_lvl(int n, int code);
    if (n < 2) return (code == 3) ? 3 : 1;
    return (code == 2) ? 2 : 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, advance the model, compare after the edge.
  task automatic cyc(input logic [9:0] r, input logic [19:0] c,
                     input bit a, input bit t, input string tag);
    bit took_ack, took_ret, f;
    int wl, wv;
    req = r; cfg = c; ack = a; reti = t;
    took_ack = a && m_irq;
    took_ret = t && !took_ack && (m_sp > 0);
    f = 1'b0; wl = 0; wv = 0;
    for (int l = 3; l > m_run && !f; l--)
      for (int n = 0; n < 10 && !f; n++)
        if (r[n] && ref_lvl(n, int'(c[2*n +: 2])) == l) begin
          f = 1'b1; wl = l; wv = 3 + 8 * n;
        end
    @(posedge clk); #1;
    if (took_ack) begin
      m_stk[m_sp] = m_run; m_sp++; m_run = m_glvl;
      m_irq = 1'b0; m_vec = 0; m_glvl = 0;
    end else begin
      if (took_ret) begin m_sp--; m_run = m_stk[m_sp]; end
      m_irq = f; m_vec = f ? wv : 0; m_glvl = f ? wl : 0;
    end
    check(tag, "irq_o", int'(irq), int'(m_irq));
    check(tag, "vec_addr_o", int'(vaddr), m_vec);
    check(tag, "run_lvl_o", int'(run), m_run);
  endtask

  function automatic logic [19:0] cfg_fill(int kind);
    logic [19:0] v = '0;
    for (int n = 0; n < 10; n++)
      case (kind)
        0: v[2*n +: 2] = 2'(n * 3 + 1);
        1: v[2*n +: 2] = 2'd3;
        2: v[2*n +: 2] = 2'd2;
        default: v[2*n +: 2] = (n == 0) ? 2'd3 : (n == 1) ? 2'd0 : ((n % 2 == 0) ? 2'd2 : 2'd1);
      endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [19:0] cs;
    logic [15:0] lf;
    // R1: outputs idle under reset even with requests present
    req = '1; cfg = cfg_fill(1);
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq_o", int'(irq), 0);
    check("R1", "vec_addr_o", int'(vaddr), 0);
    check("R1", "run_lvl_o", int'(run), 0);
    @(negedge clk); req = '0; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "irq_o after release", int'(irq), 0);
    check("R1", "run_lvl_o after release", int'(run), 0);

    // R2/R3: each vector alone, each code; ack shows the mapped level
    for (int n = 0; n < 10; n++)
      for (int code = 0; code < 4; code++) begin
        cs = '0; cs[2*n +: 2] = 2'(code);
        cyc(10'(1 << n), cs, 0, 0, "R2_R3");
        cyc('0, cs, 1, 0, "R3_R8");
        cyc('0, cs, 0, 1, "R9");
      end

    // R5/R6: every request pattern at running level none, several settings
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 1024; p++)
        cyc(10'(p), cfg_fill(k), 0, 0, "R5_R6_R7");

    // R4: sweeps at running level low, high and top
    cs = cfg_fill(3);
    cyc(10'b0000000010, cs, 0, 0, "R4");
    cyc('0, cs, 1, 0, "R8");
    for (int p = 0; p < 1024; p++) cyc(10'(p), cs, 0, 0, "R4");
    cyc(10'b0000000100, cs, 0, 0, "R4");
    cyc('0, cs, 1, 0, "R8");
    for (int p = 0; p < 1024; p++) cyc(10'(p), cs, 0, 0, "R4");
    cyc(10'b0000000001, cs, 0, 0, "R4");
    cyc('0, cs, 1, 0, "R8");
    for (int p = 0; p < 512; p++) cyc(10'(p), cs, 0, 0, "R4");
    // R9: unwind top -> high -> low -> none
    cyc('0, cs, 0, 1, "R9");
    cyc('0, cs, 0, 1, "R9");
    cyc('0, cs, 0, 1, "R9");

    // R10: ignored strobes
    cyc('0, cs, 0, 1, "R10");
    cyc('0, cs, 1, 0, "R10");
    cyc(10'b0000000010, cs, 0, 0, "R10");
    cyc('0, cs, 1, 1, "R10");
    cyc(10'b0000000100, cs, 0, 0, "R10");
    cyc(10'b0000000100, cs, 1, 1, "R10");
    cyc('0, cs, 0, 1, "R10");
    cyc('0, cs, 0, 1, "R10");

    // R8/R9: pseudo-random traffic with nesting and returns
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 64 == 0) cs = {lf[3:0], lf, 16'h0} ^ cfg_fill(i % 4);
      cyc(lf[9:0] & {lf[15:10], lf[3:0]}, cs, lf[11], lf[14] & lf[2], "R8_R9");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule